// File: doc/BRIEF.md
# Reset Sequencer with Sticky Power-On Flag

This block decides when the processor core of a small microcontroller-style system may leave reset. The requests that can hold the core in reset are a power-on event, an active-low external master-clear pin, a vector of internal requesters such as a watchdog timeout, and an "operating conditions valid" input. The external pin is brought through a two-stage synchronizer and then a digital noise filter. The filter only accepts a new pin level after that level has been seen for a set number of consecutive clocks. A configuration input can remove the pin from the set of reset requesters. When it does, the filtered pin level is offered to the rest of the chip as an ordinary digital input.

The core reset output goes low while any request is present. After the last request clears, it stays low for a fixed number of clean cycles and then rises on a clock edge. The block also keeps a single flag for software. Only a power-on clears this flag, and only a software write of 1 sets it. Software can therefore tell a power-on restart apart from every other kind of restart.

The power-on indication `por_n` is the asynchronous reset of every register in the block. The pin is an input only. No internal request has any path back to it.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_n` is 0 and `pof_flag` is 0, with no clock edge needed.
- R2: With `mclr_en` = 1, holding `mclr_pin_n` low asserts reset. The pin passes through 2 synchronizer stages and then a filter that needs FILT_LEN (default 4) consecutive low samples. `core_rst_n` therefore falls on the 7th rising edge after the pin goes low.
- R3: A low pulse on `mclr_pin_n` that lasts fewer than FILT_LEN clocks changes neither `core_rst_n` nor `pin_din`.
- R4: With `mclr_en` = 0, the pin never causes a reset, and `pin_din` follows the filtered pin level (0 on the 6th edge after the pin goes low). With `mclr_en` = 1, `pin_din` reads 1.
- R5: Any bit of `int_rst` at 1 (active high) drives `core_rst_n` to 0 on the next edge. The block has no output toward the pin.
- R6: While `cond_ok` is 0, `core_rst_n` stays 0.
- R7: Once no request is present, `core_rst_n` rises on the HOLD_CYC-th (default 8) consecutive request-free edge. A request that arrives during this count restarts it.
- R8: On an edge where `pof_wr_en` = 1 and `pof_wr_data` = 1, `pof_flag` becomes 1. A write with data 0 has no effect, and nothing else sets the flag.
- R9: `pof_flag` keeps its value through resets caused by the pin, by `int_rst` and by `cond_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on indication, active low; asynchronous reset of the block |
| mclr_pin_n | input | 1 | External master-clear pin, active low, asynchronous |
| mclr_en | input | 1 | Configuration: 1 = pin is a reset source, 0 = pin is a digital input |
| int_rst | input | N_INT | Internal reset requests (e.g. watchdog), active high |
| cond_ok | input | 1 | Operating conditions valid |
| pof_wr_en | input | 1 | Software write strobe for the power-on flag |
| pof_wr_data | input | 1 | Software write data for the power-on flag |
| pof_flag | output | 1 | Sticky power-on flag |
| pin_din | output | 1 | Filtered pin level when the pin is a digital input, else 1 |
| core_rst_n | output | 1 | Core reset, active low |

## Verification
The assertions assume that `int_rst`, `cond_ok`, `mclr_en` and the flag write port are synchronous to `clk`. Only `mclr_pin_n` and `por_n` may change at any time. They also assume that `mclr_en` is changed only while the filtered pin level is high, because switching it while the pin is held low would turn a valid digital-input level into a reset request. The bench changes every input just after a falling clock edge and toggles `mclr_en` only with the pin idle high. Short pin pulses are kept strictly below the filter length, and long ones well above it.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    HS_ASSERT = 2'd0,
    HS_DRAIN  = 2'd1,
    HS_RUN    = 2'd2
  } hold_state_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_filter.sv
module rsq_filter
  import rsq_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int CW = cnt_width(FILT_LEN);

  logic          lvl_q, lvl_d, lvl_en;
  logic [CW-1:0] run_q, run_d;
  logic          run_en;
  logic          differs;

  always_comb begin
    differs = (lvl_in != lvl_q);
    lvl_en  = 1'b0;
    lvl_d   = lvl_q;
    run_en  = 1'b1;
    run_d   = '0;
    if (differs) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        lvl_en = 1'b1;
        lvl_d  = lvl_in;
        run_d  = '0;
      end else begin
        run_d  = run_q + CW'(1);
      end
    end else if (run_q == '0) begin
      run_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else begin
      if (lvl_en) lvl_q <= lvl_d;
      if (run_en) run_q <= run_d;
    end
  end

  assign lvl_out = lvl_q;
endmodule

// File: rtl/rsq_hold.sv
module rsq_hold
  import rsq_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic run
);
  localparam int HCW = cnt_width(HOLD_CYC);

  hold_state_e    st_q, st_d;
  logic [HCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (req) begin
      st_d   = HS_ASSERT;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        HS_ASSERT, HS_DRAIN: begin
          cnt_en = 1'b1;
          if (cnt_q == HCW'(HOLD_CYC - 1)) begin
            st_d  = HS_RUN;
            cnt_d = '0;
          end else begin
            st_d  = HS_DRAIN;
            cnt_d = cnt_q + HCW'(1);
          end
        end
        default: st_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_ASSERT;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run = (st_q == HS_RUN);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 8,
  parameter int N_INT    = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mclr_pin_n,
  input  logic             mclr_en,
  input  logic [N_INT-1:0] int_rst,
  input  logic             cond_ok,
  input  logic             pof_wr_en,
  input  logic             pof_wr_data,
  output logic             pof_flag,
  output logic             pin_din,
  output logic             core_rst_n
);
  logic sync_lvl;
  logic flt_lvl;
  logic rst_req;
  logic pof_q, pof_set;

  rsq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(por_n), .d_in(mclr_pin_n), .d_out(sync_lvl)
  );

  rsq_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(por_n), .lvl_in(sync_lvl), .lvl_out(flt_lvl)
  );

  always_comb rst_req = (mclr_en && !flt_lvl) || (|int_rst) || !cond_ok;

  rsq_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(por_n), .req(rst_req), .run(core_rst_n)
  );

  always_comb pof_set = pof_wr_en && pof_wr_data;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       pof_q <= 1'b0;
    else if (pof_set) pof_q <= 1'b1;
  end

  assign pof_flag = pof_q;
  assign pin_din  = mclr_en ? 1'b1 : flt_lvl;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
  import rsq_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_CYC = 8,
  parameter int N_INT    = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic             mclr_en,
  input logic [N_INT-1:0] int_rst,
  input logic             cond_ok,
  input logic             pof_wr_en,
  input logic             pof_wr_data,
  input logic             pof_flag,
  input logic             core_rst_n,
  input logic             sync_lvl,
  input logic             flt_lvl,
  input logic             rst_req
);
  localparam int FW = cnt_width(FILT_LEN);
  localparam int QW = cnt_width(HOLD_CYC);

  logic [FW-1:0] low_run;
  logic [QW-1:0] quiet_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_run   <= '0;
      quiet_run <= '0;
    end else begin
      if (sync_lvl)                          low_run <= '0;
      else if (low_run != FW'(FILT_LEN))     low_run <= low_run + FW'(1);
      if (rst_req)                           quiet_run <= '0;
      else if (quiet_run != QW'(HOLD_CYC))   quiet_run <= quiet_run + QW'(1);
    end
  end

  AST_POR_CLEAR: assert property (@(posedge clk)
    !por_n |-> (!core_rst_n && !pof_flag)); // R1

  AST_PIN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (mclr_en && !flt_lvl) |=> !core_rst_n); // R2

  AST_FILT_MIN_LOW: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flt_lvl) |-> (low_run >= FW'(FILT_LEN))); // R3

  AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!por_n)
    (!mclr_en && !(|int_rst) && cond_ok && core_rst_n) |=> core_rst_n); // R4

  AST_INT_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (|int_rst) |=> !core_rst_n); // R5

  AST_COND_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !cond_ok |=> !core_rst_n); // R6

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> (quiet_run >= QW'(HOLD_CYC))); // R7

  AST_POF_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    (pof_wr_en && pof_wr_data) |=> pof_flag); // R8

  AST_POF_NO_HW_SET: assert property (@(posedge clk) disable iff (!por_n)
    (!pof_flag && !(pof_wr_en && pof_wr_data)) |=> !pof_flag); // R8

  AST_POF_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    pof_flag |=> pof_flag); // R9
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
  .FILT_LEN(FILT_LEN), .HOLD_CYC(HOLD_CYC), .N_INT(N_INT)
) u_chk (
  .clk(clk), .por_n(por_n), .mclr_en(mclr_en), .int_rst(int_rst),
  .cond_ok(cond_ok), .pof_wr_en(pof_wr_en), .pof_wr_data(pof_wr_data),
  .pof_flag(pof_flag), .core_rst_n(core_rst_n), .sync_lvl(sync_lvl),
  .flt_lvl(flt_lvl), .rst_req(rst_req)
);

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT_LEN   = 4;
  localparam int HOLD_CYC   = 8;
  localparam int N_INT      = 2;

  logic clk = 1'b0;
  logic por_n, pin_n, en, cond, wr_en, wr_d;
  logic [N_INT-1:0] irq;
  logic pof_flag, pin_din, core_rst_n;

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_seq_ctrl #(.FILT_LEN(FILT_LEN), .HOLD_CYC(HOLD_CYC), .N_INT(N_INT)) u_rst_seq_ctrl (
    .clk(clk), .por_n(por_n), .mclr_pin_n(pin_n), .mclr_en(en), .int_rst(irq),
    .cond_ok(cond), .pof_wr_en(wr_en), .pof_wr_data(wr_d),
    .pof_flag(pof_flag), .pin_din(pin_din), .core_rst_n(core_rst_n)
  );

  // Behavioural reference model
  bit pin_q[$];
  bit m_flt, m_inrst, m_pof;
  int m_run, m_hold;
  bit m_din;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_q = '{1'b1, 1'b1};
      m_flt = 1'b1; m_run = 0; m_inrst = 1'b1; m_hold = 0; m_pof = 1'b0;
    end else begin
      bit seen, req;
      req  = (en && !m_flt) || (irq != '0) || !cond;
      seen = pin_q.pop_front();
      pin_q.push_back(pin_n);
      if (seen != m_flt) begin
        m_run++;
        if (m_run == FILT_LEN) begin m_flt = seen; m_run = 0; end
      end else m_run = 0;
      if (req) begin m_inrst = 1'b1; m_hold = 0; end
      else if (m_inrst) begin
        m_hold++;
        if (m_hold == HOLD_CYC) begin m_inrst = 1'b0; m_hold = 0; end
      end
      if (wr_en && wr_d) m_pof = 1'b1;
    end
  end

  always_comb m_din = en ? 1'b1 : m_flt;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(phase, "model core_rst_n", core_rst_n, !m_inrst);
      chk(phase, "model pof_flag", pof_flag, m_pof);
      chk(phase, "model pin_din", pin_din, m_din);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; pin_n = 1'b1; en = 1'b1; cond = 1'b0;
    wr_en = 1'b0; wr_d = 1'b0; irq = '0;
    #1;
    chk("R1", "core_rst_n in por", core_rst_n, 1'b0);
    chk("R1", "pof_flag in por", pof_flag, 1'b0);
    step(3);
    por_n = 1'b1;
    phase = "R6";
    step(6);
    chk("R6", "core held, cond low", core_rst_n, 1'b0);
    cond = 1'b1;
    phase = "R7";
    step(HOLD_CYC - 1);
    chk("R7", "still in reset", core_rst_n, 1'b0);
    step(1);
    chk("R7", "released", core_rst_n, 1'b1);

    phase = "R8";
    wr_en = 1'b1; wr_d = 1'b0;
    step(1); wr_en = 1'b0;
    step(1);
    chk("R8", "write 0 ignored", pof_flag, 1'b0);
    wr_en = 1'b1; wr_d = 1'b1;
    step(1); wr_en = 1'b0; wr_d = 1'b0;
    chk("R8", "write 1 sets", pof_flag, 1'b1);

    phase = "R3";
    pin_n = 1'b0; step(FILT_LEN - 1); pin_n = 1'b1;
    step(3);
    pin_n = 1'b0; step(1); pin_n = 1'b1;
    step(10);
    chk("R3", "short pulses ignored", core_rst_n, 1'b1);

    phase = "R2";
    pin_n = 1'b0;
    step(6);
    chk("R2", "not yet reset", core_rst_n, 1'b1);
    step(1);
    chk("R2", "pin reset", core_rst_n, 1'b0);
    step(5);
    chk("R9", "flag kept over pin reset", pof_flag, 1'b1);
    pin_n = 1'b1;
    step(20);
    chk("R2", "recovered", core_rst_n, 1'b1);

    phase = "R4";
    en = 1'b0;
    #1;
    chk("R4", "pin_din idle", pin_din, 1'b1);
    pin_n = 1'b0;
    step(5);
    chk("R4", "pin_din before filter", pin_din, 1'b1);
    step(1);
    chk("R4", "pin_din low", pin_din, 1'b0);
    step(14);
    chk("R4", "no reset when disabled", core_rst_n, 1'b1);
    pin_n = 1'b1;
    step(6);
    chk("R4", "pin_din high", pin_din, 1'b1);
    en = 1'b1;
    #1;
    chk("R4", "pin_din forced 1", pin_din, 1'b1);

    phase = "R5";
    step(1);
    irq = 2'b01; step(1); irq = '0;
    chk("R5", "watchdog reset", core_rst_n, 1'b0);
    phase = "R7";
    step(4);
    irq = 2'b10; step(1); irq = '0;
    chk("R5", "second source", core_rst_n, 1'b0);
    step(HOLD_CYC - 1);
    chk("R7", "count restarted", core_rst_n, 1'b0);
    step(1);
    chk("R7", "released after restart", core_rst_n, 1'b1);
    chk("R9", "flag kept over internal reset", pof_flag, 1'b1);

    phase = "R9";
    cond = 1'b0; step(3); cond = 1'b1;
    step(HOLD_CYC + 2);
    chk("R9", "flag kept over cond reset", pof_flag, 1'b1);

    phase = "R1";
    por_n = 1'b0;
    #1;
    chk("R1", "por clears flag", pof_flag, 1'b0);
    chk("R1", "por asserts reset", core_rst_n, 1'b0);
    step(2);
    por_n = 1'b1;
    step(HOLD_CYC + 2);
    chk("R8", "flag stays 0 after por", pof_flag, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule